// File: doc/BRIEF.md
# Receive Character Queue with Line Status View

This block sits between a receive deserializer and a host bus. Each finished character comes in on a push interface together with three tags: break, framing error and parity error. The character and its tags are stored as one entry in a first-in first-out queue. The host sees the oldest character on `head_data`. It also sees a 16-bit line status word that combines queue occupancy, the tags of the oldest entry, a sticky overrun flag, a flag meaning "some tagged entry is still queued", and two empty indications taken from the transmit side.

A host read of the data register (`rd_data_strobe`) removes the oldest entry, so the head character and the head tags move on to the next entry. A host read of the status register (`rd_stat_strobe`) never moves the queue. Its only effect is to clear overrun.

The design is built around three state machines:
- **Occupancy machine** (`rxf_store`), with states `LV_EMPTY`, `LV_PARTIAL` and `LV_FULL`:
  - first accepted push: `LV_EMPTY` to `LV_PARTIAL`;
  - last free slot filled: `LV_PARTIAL` to `LV_FULL`;
  - last entry popped: `LV_PARTIAL` to `LV_EMPTY`;
  - pop without a push: `LV_FULL` to `LV_PARTIAL`.
- **Overrun machine** (`rxf_overrun`), with states `OV_CLEAR` and `OV_FLAGGED`:
  - dropped push: `OV_CLEAR` to `OV_FLAGGED`;
  - status read with no drop in the same cycle: `OV_FLAGGED` to `OV_CLEAR`.
- **Tagged-entry counter** (`rxf_tagcount`): counts queued entries that carry any tag.

Top module: `uart_rx_fifo_lsr`

## Requirements
- R1: `status[0]` is 1 exactly when the queue holds at least one entry. `head_data` is the oldest queued character, and characters leave in arrival order. The queue holds DEPTH entries.
- R2: `status[4]`, `status[3]` and `status[2]` show the break, framing and parity tags of the head entry. When the queue is empty, these bits and `head_data` are 0.
- R3: A high `rd_data_strobe` with a non-empty queue pops the head at the clock edge. `rd_stat_strobe` never changes `head_data` or the occupancy.
- R4: `status[7]` is 1 while any queued entry has at least one tag set. It is 0 once no tagged entry remains.
- R5: A push arriving while the queue is full and no pop happens in the same cycle is dropped. The queue contents are unchanged, and `status[1]` (overrun) reads 1 from the next cycle.
- R6: A push to a full queue in the same cycle as a pop is accepted, and it does not set overrun.
- R7: A status read clears overrun at the clock edge. If a dropped push happens in the same cycle, overrun stays 1.
- R8: `status[5]` equals `tx_fifo_empty`. `status[6]` equals `tx_fifo_empty` AND `tx_shift_empty`.
- R9: `status[15:8]` always read 0. After reset the queue is empty, overrun is 0 and the tagged count is 0.
- R10: A data read while the queue is empty has no effect. A push in that same cycle is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Deserializer offers a finished character |
| push_data | input | 8 | Character value |
| push_brk | input | 1 | Break tag of the character |
| push_frm | input | 1 | Framing-error tag of the character |
| push_par | input | 1 | Parity-error tag of the character |
| tx_fifo_empty | input | 1 | Transmit queue is empty |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| rd_data_strobe | input | 1 | Host reads the data register (pops) |
| rd_stat_strobe | input | 1 | Host reads the status register (clears overrun) |
| head_data | output | 8 | Oldest queued character, 0 when empty |
| status | output | 16 | Line status word |

## Verification
The bench builds the block with DEPTH set to 4, so the full boundary is only four pushes away. At that depth the bench can sweep every fill level from empty to full against every combination of push, data read and status read, with each tag pattern and each pair of transmit flags. This reaches the drop-on-full case, the push-with-pop-on-full case, pop-on-empty, and an overrun set that coincides with a status read. A long pseudo-random phase then exercises the tagged-entry count as tagged entries enter and leave in mixed orders.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;
    localparam int CHAR_W = 8;
    localparam int STAT_W = 16;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [CHAR_W-1:0] ch;
    } rx_entry_t;

    typedef enum logic [1:0] {
        LV_EMPTY   = 2'd0,
        LV_PARTIAL = 2'd1,
        LV_FULL    = 2'd2
    } level_e;

    typedef enum logic {
        OV_CLEAR   = 1'b0,
        OV_FLAGGED = 1'b1
    } ovr_e;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import uart_rxf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_req,
    input  rx_entry_t entry_in,
    input  logic      pop_req,
    output rx_entry_t head,
    output logic      push_ok,
    output logic      pop_ok,
    output logic      non_empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    level_e        level_q, level_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [PW-1:0] wr_ptr, rd_ptr;
    rx_entry_t     mem [DEPTH];

    assign pop_ok    = pop_req && (level_q != LV_EMPTY);
    assign push_ok   = push_req && ((level_q != LV_FULL) || pop_ok);
    assign non_empty = (level_q != LV_EMPTY);
    assign head      = non_empty ? mem[rd_ptr] : '0;

    always_comb begin
        cnt_d = cnt_q;
        if (push_ok && !pop_ok)
            cnt_d = cnt_q + 1'b1;
        else if (pop_ok && !push_ok)
            cnt_d = cnt_q - 1'b1;
    end

    always_comb begin
        level_d = level_q;
        unique case (level_q)
            LV_EMPTY:   if (push_ok) level_d = (cnt_d == FULL_CNT) ? LV_FULL : LV_PARTIAL;
            LV_PARTIAL: begin
                if (cnt_d == '0)            level_d = LV_EMPTY;
                else if (cnt_d == FULL_CNT) level_d = LV_FULL;
            end
            LV_FULL:    if (cnt_d != FULL_CNT) level_d = (cnt_d == '0) ? LV_EMPTY : LV_PARTIAL;
            default:    level_d = LV_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= LV_EMPTY;
            cnt_q   <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else begin
            level_q <= level_d;
            cnt_q   <= cnt_d;
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= entry_in;
    end

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);
    p_rdptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_req |=> $stable(rd_ptr));
    p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && level_q == LV_FULL && !pop_req) |=> ($stable(cnt_q) && $stable(wr_ptr)));
    p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q == LV_EMPTY) |-> !pop_ok);
endmodule

// File: rtl/rxf_tagcount.sv
module rxf_tagcount #(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_ok,
    input  logic push_tagged,
    input  logic pop_ok,
    input  logic pop_tagged,
    output logic any_err
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] tag_cnt;
    logic          inc, dec;

    assign inc     = push_ok && push_tagged;
    assign dec     = pop_ok && pop_tagged;
    assign any_err = (tag_cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tag_cnt <= '0;
        else if (inc && !dec)
            tag_cnt <= tag_cnt + 1'b1;
        else if (dec && !inc)
            tag_cnt <= tag_cnt - 1'b1;
    end

    p_tag_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (tag_cnt != '0));
    p_tag_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tag_cnt <= CW'(DEPTH));
endmodule

// File: rtl/rxf_overrun.sv
module rxf_overrun
    import uart_rxf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lost,
    input  logic stat_rd,
    output logic ovr
);
    ovr_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OV_CLEAR:   if (lost) state_d = OV_FLAGGED;
            OV_FLAGGED: if (stat_rd && !lost) state_d = OV_CLEAR;
            default:    state_d = OV_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OV_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        ovr = (state_q == OV_FLAGGED);
    end

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> ovr);
    p_clear_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && stat_rd && !lost) |=> !ovr);
endmodule

// File: rtl/uart_rx_fifo_lsr.sv
module uart_rx_fifo_lsr
    import uart_rxf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [CHAR_W-1:0] push_data,
    input  logic              push_brk,
    input  logic              push_frm,
    input  logic              push_par,
    input  logic              tx_fifo_empty,
    input  logic              tx_shift_empty,
    input  logic              rd_data_strobe,
    input  logic              rd_stat_strobe,
    output logic [CHAR_W-1:0] head_data,
    output logic [STAT_W-1:0] status
);
    rx_entry_t entry_in, head;
    logic      push_ok, pop_ok, non_empty, any_err, ovr;

    assign entry_in = '{brk: push_brk, frm: push_frm, par: push_par, ch: push_data};

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_valid),
        .entry_in  (entry_in),
        .pop_req   (rd_data_strobe),
        .head      (head),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .non_empty (non_empty)
    );

    rxf_tagcount #(.DEPTH(DEPTH)) u_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_ok     (push_ok),
        .push_tagged (push_brk | push_frm | push_par),
        .pop_ok      (pop_ok),
        .pop_tagged  (head.brk | head.frm | head.par),
        .any_err     (any_err)
    );

    rxf_overrun u_ovr (
        .clk     (clk),
        .rst_n   (rst_n),
        .lost    (push_valid && !push_ok),
        .stat_rd (rd_stat_strobe),
        .ovr     (ovr)
    );

    assign head_data = head.ch;
    assign status    = {8'h00, any_err, tx_fifo_empty & tx_shift_empty, tx_fifo_empty,
                        head.brk, head.frm, head.par, ovr, non_empty};

    p_empty_head_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !status[0] |-> (head_data == '0 && status[4:2] == 3'b000));
    p_err_needs_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status[7] |-> status[0]);
    p_stat_read_no_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat_strobe && !rd_data_strobe && !push_valid) |=> ($stable(head_data) && $stable(status[0])));
endmodule

// File: tb/tb_uart_rx_fifo_lsr.sv
module tb_uart_rx_fifo_lsr;
    localparam int CLK_PERIOD = 10;
    localparam int D = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 0, push_brk = 0, push_frm = 0, push_par = 0;
    logic [7:0] push_data = 0;
    logic       tx_fifo_empty = 1, tx_shift_empty = 1;
    logic       rd_data_strobe = 0, rd_stat_strobe = 0;
    logic [7:0] head_data;
    logic [15:0] status;

    int n_checks = 0, n_fail = 0;
    logic [10:0] q [D];
    int  mcnt = 0;
    bit  movr = 0;
    bit  done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_fifo_lsr #(.DEPTH(D)) dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .push_brk(push_brk), .push_frm(push_frm), .push_par(push_par),
        .tx_fifo_empty(tx_fifo_empty), .tx_shift_empty(tx_shift_empty),
        .rd_data_strobe(rd_data_strobe), .rd_stat_strobe(rd_stat_strobe),
        .head_data(head_data), .status(status)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int tagged_in_model();
        int n = 0;
        for (int i = 0; i < mcnt; i++) if (q[i][10:8] != 3'b000) n++;
        return n;
    endfunction

    task automatic check_all();
        logic [2:0] etag;
        logic [7:0] ech;
        etag = (mcnt > 0) ? q[0][10:8] : 3'b000;
        ech  = (mcnt > 0) ? q[0][7:0] : 8'h00;
        chk(status[0] == (mcnt > 0), "R1 nonempty bit", status[0], mcnt > 0);
        chk(head_data == ech, "R1 head character", head_data, ech);
        chk(status[4:2] == etag, "R2 head tags", status[4:2], etag);
        chk(status[1] == movr, "R5 R7 overrun bit", status[1], movr);
        chk(status[7] == (tagged_in_model() != 0), "R4 tagged-entry flag", status[7], tagged_in_model() != 0);
        chk(status[6:5] == {tx_fifo_empty & tx_shift_empty, tx_fifo_empty}, "R8 transmit flags",
            status[6:5], {tx_fifo_empty & tx_shift_empty, tx_fifo_empty});
        chk(status[15:8] == 8'h00, "R9 upper byte", status[15:8], 0);
    endtask

    // One clock: drive after a falling edge, update the model at the rising edge, check at the next falling edge.
    task automatic cyc(input bit pv, input logic [7:0] d, input logic [2:0] tg,
                       input bit rdd, input bit rds);
        bit pop, acc;
        push_valid = pv; push_data = d; {push_brk, push_frm, push_par} = tg;
        rd_data_strobe = rdd; rd_stat_strobe = rds;
        @(posedge clk);
        pop = rdd && (mcnt > 0);
        acc = pv && ((mcnt < D) || pop);
        if (pop) begin
            for (int i = 0; i < D - 1; i++) q[i] = q[i + 1];
            mcnt--;
        end
        if (acc) begin
            q[mcnt] = {tg, d};
            mcnt++;
        end
        movr = (pv && !acc) ? 1'b1 : (rds ? 1'b0 : movr);
        @(negedge clk);
        push_valid = 0; rd_data_strobe = 0; rd_stat_strobe = 0;
        check_all();
    endtask

    task automatic drain();
        while (mcnt > 0 || movr) cyc(0, 0, 0, 1, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic [7:0]  hold;
        for (int i = 0; i < D; i++) q[i] = '0;
        repeat (3) @(negedge clk);
        // R9: reset state with both transmit flags high reads 0x0060
        chk(status == 16'h0060, "R9 reset status", status, 16'h0060);
        chk(head_data == 8'h00, "R9 reset head", head_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all();

        // Sweep: every fill level x every (push, data read, status read) x tag patterns x transmit flags.
        // R3 R6 R10 are covered by combos at level 0 (pop on empty) and at level D (push with pop).
        for (int lvl = 0; lvl <= D; lvl++)
            for (int combo = 0; combo < 8; combo++)
                for (int tg = 0; tg < 8; tg++)
                    for (int tx = 0; tx < 4; tx++) begin
                        {tx_fifo_empty, tx_shift_empty} = tx[1:0];
                        drain();
                        for (int k = 0; k < lvl; k++)
                            cyc(1, 8'(lvl * 16 + k + 1), 3'((k + tg) % 8), 0, 0);
                        cyc(combo[0], 8'(8'hA0 + tg), 3'(tg), combo[1], combo[2]);
                        cyc(0, 0, 0, 0, 1);
                    end

        // R6: full queue, push together with pop, no overrun
        tx_fifo_empty = 1; tx_shift_empty = 0;
        drain();
        for (int k = 0; k < D; k++) cyc(1, 8'(k + 1), 3'b000, 0, 0);
        cyc(1, 8'h55, 3'b001, 1, 0);
        chk(status[1] == 1'b0, "R6 no overrun on push with pop", status[1], 0);
        chk(head_data == 8'h02, "R6 head advanced", head_data, 2);

        // R5: full and push alone, dropped; R7 set wins over a same-cycle status read
        cyc(1, 8'h66, 3'b100, 0, 1);
        chk(status[1] == 1'b1, "R7 set wins over status read", status[1], 1);
        cyc(0, 0, 0, 0, 1);
        chk(status[1] == 1'b0, "R7 status read clears overrun", status[1], 0);

        // R3: status read leaves head unchanged
        hold = head_data;
        cyc(0, 0, 0, 0, 1);
        chk(head_data == hold && status[0], "R3 status read does not pop", head_data, hold);

        // R10: pop on empty with push keeps the push
        drain();
        cyc(1, 8'h7E, 3'b010, 1, 0);
        chk(head_data == 8'h7E && status[3], "R10 push kept during empty pop", head_data, 8'h7E);

        // Pseudo-random mixed traffic for R4 tag counting
        lfsr = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            {tx_fifo_empty, tx_shift_empty} = lfsr[9:8];
            cyc(lfsr[0] | lfsr[1], lfsr[15:8], (lfsr[4:2] == 3'b111) ? 3'(lfsr[7:5]) : 3'b000,
                lfsr[5] & lfsr[6] | (n[9] & lfsr[7]), lfsr[3] & lfsr[11]);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule